// File: doc/BRIEF.md
# Inverter Gate Protection Controller

This block sits between a PWM generator and the six gate drivers of a three-phase half bridge. Every phase has one high-side and one low-side command, all active high. Each command reaches its gate only while that gate is armed and nothing blocks it. The fault inputs are already digitized and synchronized. They are a low-side short-circuit flag, a low-side supply undervoltage pair (trip and reset-level flags), an over-temperature pair (trip and reset-level flags) and one undervoltage pair for each high-side supply. The block drives an active-low fault output in open-drain style: it drives low or releases.

Each low-side fault removes all three low-side gates in the same cycle and starts the fault FSM. The FSM has three states. FS_IDLE releases the fault output. FS_PULSE holds the fault output low for FO_MIN_CYCLES cycles, counted from the last cycle in which a trip input was high. FS_HOLD keeps the fault output low after the pulse while an undervoltage or over-temperature latch is still set. Its transitions are:
- idle-to-pulse on any trip;
- pulse-reload on a trip while in FS_PULSE;
- pulse-to-hold when the count expires with a latch set;
- pulse-to-idle when the count expires with no latch set;
- hold-to-pulse on a new trip;
- hold-to-idle when both latches clear.

Each two-threshold latch has two states, LT_CLEAR and LT_TRIPPED. It moves clear-to-tripped on its trip flag. It moves tripped-to-clear only when the reset-level flag is high and the trip flag is low. A high-side undervoltage latch blocks only the high-side gate of its own phase and never touches the fault output.

Each gate has a two-state arm FSM, GA_DISARMED and GA_ARMED. It moves armed-to-disarmed whenever the gate is blocked. It moves disarmed-to-armed only on a low-to-high transition of its own command seen while unblocked. A phase whose two commands are both high has both gates vetoed. This veto leaves the arm state and the fault output alone.

Top module: `inv_gate_guard`

## Requirements
- R1: While `sc_flag` is 1, all bits of `gate_lo` are 0 in that same cycle, regardless of `cmd_lo`. `gate_hi` is not affected.
- R2: A short-circuit trip drives `fault_n` to 0 from the cycle after the first cycle `sc_flag` is 1. When no latch is set, `fault_n` returns to 1 after exactly FO_MIN_CYCLES cycles counted from the cycle after the last cycle in which `sc_flag` was 1.
- R3: `lsuv_trip`=1 sets the low-side undervoltage latch. The latch clears only on a clock edge where `lsuv_ok`=1 and `lsuv_trip`=0. While the trip or the latch is active, `gate_lo` is 0. `fault_n` stays 0 for at least FO_MIN_CYCLES cycles and until the latch has cleared. `fault_n` returns to 1 two clock edges after `lsuv_ok` rises, once the pulse has expired.
- R4: `ot_trip` and `ot_ok` behave as the trip and reset-level flags of an identical latch with the same effect on `gate_lo` and `fault_n`. If `ot_ok` is already 1 when a one-cycle trip occurs, `fault_n` is low for exactly FO_MIN_CYCLES cycles.
- R5: `hsuv_trip[i]`=1 sets latch i, which clears only when `hsuv_ok[i]`=1 and `hsuv_trip[i]`=0. While the trip or latch i is active, `gate_hi[i]` is 0. The other phases' gates are unaffected and `fault_n` stays 1.
- R6: After a blocking condition ends, a gate stays 0 even with its command held at 1. It turns on only after its command goes 0 and then 1 with the gate unblocked, one cycle after that rising command. Each of the six gates re-arms independently. For low-side gates, blocking includes every cycle with `fault_n`=0.
- R7: After reset, all gates are 0 and `fault_n` is 1. A command held at 1 through reset does not turn its gate on until it goes 0 and then 1.
- R8: When `cmd_hi[i]` and `cmd_lo[i]` are both 1, `gate_hi[i]` and `gate_lo[i]` are 0 and `fault_n` is unchanged. The arm state is kept, so when one command drops, the other gate is driven again at once.
- R9: Any trip input at 1 while `fault_n` is 0 restarts the FO_MIN_CYCLES count, which then runs from the cycle after that trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_hi | input | NPH | High-side PWM commands, active high |
| cmd_lo | input | NPH | Low-side PWM commands, active high |
| sc_flag | input | 1 | Low-side short-circuit flag |
| lsuv_trip | input | 1 | Low-side supply below trip level |
| lsuv_ok | input | 1 | Low-side supply above reset level |
| ot_trip | input | 1 | Temperature above trip level |
| ot_ok | input | 1 | Temperature below reset level |
| hsuv_trip | input | NPH | Per-phase high-side supply below trip level |
| hsuv_ok | input | NPH | Per-phase high-side supply above reset level |
| gate_hi | output | NPH | Gated high-side enables |
| gate_lo | output | NPH | Gated low-side enables |
| fault_n | output | 1 | Fault indication, active low |

## Verification
The assertions check the following on every cycle:
- a short-circuit flag, a high-side trip or a shoot-through pair always leaves the affected gates off;
- an undervoltage or over-temperature trip pulls `fault_n` low on the next cycle;
- every low period of `fault_n` lasts at least FO_MIN_CYCLES;
- a trip during an asserted fault reloads the counter;
- a gate never returns while its command stays high across the end of a block.

Only the bench scenarios can show the cycle-exact pulse widths, the two-edge recovery delay after a reset-level flag, the need for a fresh command edge after reset, and the independent re-arming of each phase after overlapping faults.

// File: rtl/gp_pkg.sv
package gp_pkg;
    typedef enum logic [1:0] {FS_IDLE, FS_PULSE, FS_HOLD} fault_state_t;
    typedef enum logic {LT_CLEAR, LT_TRIPPED} latch_state_t;
    typedef enum logic {GA_DISARMED, GA_ARMED} arm_state_t;
endpackage

// File: rtl/gp_trip_latch.sv
module gp_trip_latch
    import gp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic ok,
    output logic tripped
);
    latch_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LT_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LT_CLEAR:   if (trip) state_d = LT_TRIPPED;
            LT_TRIPPED: if (ok && !trip) state_d = LT_CLEAR;
            default:    state_d = LT_CLEAR;
        endcase
    end

    always_comb tripped = trip || (state_q == LT_TRIPPED);

    // R3 (same latch serves R4 and R5): reset flag alone never clears while tripping
    p_trip_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> tripped || (ok && !trip));
    p_ok_needed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tripped) && !$past(ok) |-> tripped);
endmodule

// File: rtl/gp_fault_fsm.sv
module gp_fault_fsm
    import gp_pkg::*;
#(
    parameter int FO_MIN_CYCLES = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_any,
    input  logic hold_req,
    output logic fault_n
);
    localparam int CW = (FO_MIN_CYCLES < 2) ? 1 : $clog2(FO_MIN_CYCLES);
    localparam logic [CW-1:0] LOAD = CW'(FO_MIN_CYCLES - 1);
    localparam int RW = CW + 1;
    localparam logic [RW-1:0] RMAX = {RW{1'b1}};

    fault_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            FS_IDLE: if (trip_any) begin
                state_d = FS_PULSE;
                cnt_d   = LOAD;
            end
            FS_PULSE: begin
                if (trip_any)            cnt_d = LOAD;
                else if (cnt_q == '0)    state_d = hold_req ? FS_HOLD : FS_IDLE;
                else                     cnt_d = cnt_q - 1'b1;
            end
            FS_HOLD: begin
                if (trip_any) begin
                    state_d = FS_PULSE;
                    cnt_d   = LOAD;
                end else if (!hold_req) begin
                    state_d = FS_IDLE;
                end
            end
            default: state_d = FS_IDLE;
        endcase
    end

    always_comb fault_n = (state_q == FS_IDLE);

    // checker support: length of the current low period, saturating
    logic [RW-1:0] lowrun_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  lowrun_q <= '0;
        else if (state_q == FS_IDLE) lowrun_q <= '0;
        else if (lowrun_q != RMAX)   lowrun_q <= lowrun_q + 1'b1;
    end

    p_fault_min_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_n) |-> (int'(lowrun_q) >= FO_MIN_CYCLES));
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && trip_any) |=> (state_q == FS_PULSE) && (cnt_q == LOAD));
endmodule

// File: rtl/gp_gate_arm.sv
module gp_gate_arm
    import gp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd,
    input  logic blk,
    input  logic veto,
    output logic gate
);
    arm_state_t st_q, st_d;
    logic cmd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= GA_DISARMED;
            cmd_q <= 1'b1;
        end else begin
            st_q  <= st_d;
            cmd_q <= cmd;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            GA_DISARMED: if (!blk && cmd && !cmd_q) st_d = GA_ARMED;
            GA_ARMED:    if (blk) st_d = GA_DISARMED;
            default:     st_d = GA_DISARMED;
        endcase
    end

    always_comb gate = (st_q == GA_ARMED) && cmd && !blk && !veto;

    p_rearm_needs_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(blk) && !blk && cmd && $past(cmd)) |-> !gate);
endmodule

// File: rtl/inv_gate_guard.sv
module inv_gate_guard #(
    parameter int NPH           = 3,
    parameter int FO_MIN_CYCLES = 4000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] cmd_hi,
    input  logic [NPH-1:0] cmd_lo,
    input  logic           sc_flag,
    input  logic           lsuv_trip,
    input  logic           lsuv_ok,
    input  logic           ot_trip,
    input  logic           ot_ok,
    input  logic [NPH-1:0] hsuv_trip,
    input  logic [NPH-1:0] hsuv_ok,
    output logic [NPH-1:0] gate_hi,
    output logic [NPH-1:0] gate_lo,
    output logic           fault_n
);
    logic lsuv_hold, ot_hold, blk_lo, trip_any;
    logic [NPH-1:0] hsuv_hold, shoot;

    gp_trip_latch u_lsuv (.clk(clk), .rst_n(rst_n), .trip(lsuv_trip), .ok(lsuv_ok), .tripped(lsuv_hold));
    gp_trip_latch u_ot   (.clk(clk), .rst_n(rst_n), .trip(ot_trip),   .ok(ot_ok),   .tripped(ot_hold));

    always_comb trip_any = sc_flag || lsuv_trip || ot_trip;

    gp_fault_fsm #(.FO_MIN_CYCLES(FO_MIN_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .trip_any(trip_any),
        .hold_req(lsuv_hold || ot_hold), .fault_n(fault_n));

    always_comb blk_lo = sc_flag || lsuv_hold || ot_hold || !fault_n;

    for (genvar i = 0; i < NPH; i++) begin : g_ph
        assign shoot[i] = cmd_hi[i] && cmd_lo[i];

        gp_trip_latch u_hsuv (.clk(clk), .rst_n(rst_n), .trip(hsuv_trip[i]),
                              .ok(hsuv_ok[i]), .tripped(hsuv_hold[i]));
        gp_gate_arm u_hi (.clk(clk), .rst_n(rst_n), .cmd(cmd_hi[i]), .blk(hsuv_hold[i]),
                          .veto(shoot[i]), .gate(gate_hi[i]));
        gp_gate_arm u_lo (.clk(clk), .rst_n(rst_n), .cmd(cmd_lo[i]), .blk(blk_lo),
                          .veto(shoot[i]), .gate(gate_lo[i]));

        p_hs_uv_own_r5: assert property (@(posedge clk) disable iff (!rst_n)
            hsuv_trip[i] |-> !gate_hi[i]);
        p_shoot_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_hi[i] && cmd_lo[i]) |-> !gate_hi[i] && !gate_lo[i]);
    end

    p_sc_lo_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sc_flag |-> gate_lo == '0);
    p_uv_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lsuv_trip |=> !fault_n);
    p_ot_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ot_trip |=> !fault_n);
endmodule

// File: tb/tb_inv_gate_guard.sv
`timescale 1ns/100ps
module tb_inv_gate_guard;
    localparam int NPH = 3;
    localparam int F   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NPH-1:0] cmd_hi = '0, cmd_lo = '0, hsuv_trip = '0, hsuv_ok = '0;
    logic sc_flag = 0, lsuv_trip = 0, lsuv_ok = 0, ot_trip = 0, ot_ok = 0;
    logic [NPH-1:0] gate_hi, gate_lo;
    logic fault_n;

    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    inv_gate_guard #(.NPH(NPH), .FO_MIN_CYCLES(F)) dut (.*);

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    function automatic int low_run_dummy(); return 0; endfunction

    task automatic count_low(output int n);
        n = 0;
        while (!fault_n && n < 1000) begin
            n++;
            tick();
        end
    endtask

    task automatic arm_all();
        cmd_hi = '0; cmd_lo = '0; tick();
        cmd_hi = '1; tick();
        cmd_hi = '0; cmd_lo = '1; tick();
    endtask

    task automatic t_reset();
        cmd_lo = 3'b001;
        tick(3);
        rst_n = 1'b1;
        tick();
        chk("R7 gate_lo after reset", gate_lo, 0);
        chk("R7 gate_hi after reset", gate_hi, 0);
        chk("R7 fault_n after reset", fault_n, 1);
        tick(2);
        chk("R7 held command stays off", gate_lo, 0);
        cmd_lo = 0; tick();
        cmd_lo = 3'b001; tick();
        chk("R7 fresh edge turns on", gate_lo, 1);
    endtask

    task automatic t_arm_keep();
        arm_all();
        chk("R6 low gates armed", gate_lo, 7);
        cmd_lo = '0; cmd_hi = '1; #1;
        chk("R6 high arm kept while command low", gate_hi, 7);
        tick();
    endtask

    task automatic t_shoot();
        arm_all();
        cmd_hi = 3'b010; #1;
        chk("R8 shoot phase both off lo", gate_lo, 3'b101);
        chk("R8 shoot phase both off hi", gate_hi, 0);
        tick(2);
        chk("R8 no fault on shoot", fault_n, 1);
        cmd_hi = 0; #1;
        chk("R8 arm kept after shoot", gate_lo, 7);
        tick();
    endtask

    task automatic t_sc();
        int n;
        arm_all();
        cmd_lo = 3'b011; cmd_hi = 3'b100; tick();
        sc_flag = 1; #1;
        chk("R1 low gates off at once", gate_lo, 0);
        chk("R1 high side unaffected", gate_hi, 3'b100);
        tick(); sc_flag = 0;
        count_low(n);
        chk("R2 sc pulse width", n, F);
        chk("R6 stays off with command high", gate_lo, 0);
        cmd_lo = 0; tick();
        cmd_lo = 3'b011; tick();
        chk("R6 rearm after sc", gate_lo, 3'b011);
        cmd_hi = 0; tick();
    endtask

    task automatic t_restart();
        int n;
        sc_flag = 1; tick(); sc_flag = 0;
        tick(4);
        sc_flag = 1; tick(); sc_flag = 0;
        count_low(n);
        chk("R9 count restarts on new trip", n, F);
    endtask

    task automatic t_lsuv();
        arm_all();
        lsuv_ok = 0;
        lsuv_trip = 1; #1;
        chk("R3 low gates off on uv", gate_lo, 0);
        tick(); lsuv_trip = 0;
        tick(F + 10);
        chk("R3 fault held past pulse", fault_n, 0);
        lsuv_ok = 1; tick();
        chk("R3 still low one edge after ok", fault_n, 0);
        tick();
        chk("R3 released two edges after ok", fault_n, 1);
        chk("R6 uv recovery needs edge", gate_lo, 0);
        cmd_lo = 0; tick(); cmd_lo = '1; tick();
        chk("R6 rearm after uv", gate_lo, 7);
    endtask

    task automatic t_ot();
        int n;
        arm_all();
        ot_ok = 1;
        ot_trip = 1; #1;
        chk("R4 low gates off on ot", gate_lo, 0);
        tick(); ot_trip = 0;
        count_low(n);
        chk("R4 short ot pulse width", n, F);
    endtask

    task automatic t_hsuv();
        cmd_lo = 0; cmd_hi = 0; tick();
        cmd_hi = '1; tick();
        chk("R5 high gates armed", gate_hi, 7);
        hsuv_ok = 0;
        hsuv_trip = 3'b010; #1;
        chk("R5 only own phase off", gate_hi, 3'b101);
        tick(); hsuv_trip = 0;
        tick(5);
        chk("R5 latched off", gate_hi, 3'b101);
        chk("R5 no fault output", fault_n, 1);
        hsuv_ok = 3'b010; tick(2);
        chk("R6 high side needs edge", gate_hi, 3'b101);
        cmd_hi = 3'b101; tick(); cmd_hi = '1; tick();
        chk("R6 high side rearm", gate_hi, 7);
        cmd_hi = 0; hsuv_ok = 0; tick();
    endtask

    task automatic t_overlap();
        arm_all();
        ot_ok = 0;
        sc_flag = 1; ot_trip = 1; tick();
        sc_flag = 0; ot_trip = 0;
        tick(F + 5);
        chk("R4 ot holds after sc pulse", fault_n, 0);
        ot_ok = 1; tick(2);
        chk("R4 released after ot ok", fault_n, 1);
        cmd_lo = 3'b110; tick(); cmd_lo = '1; tick();
        chk("R6 only toggled phase rearms", gate_lo, 3'b001);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_arm_keep();
        t_shoot();
        t_sc();
        t_restart();
        t_lsuv();
        t_ot();
        t_hsuv();
        t_overlap();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=1 exp=0");
        finish_run();
    end
endmodule